// File: doc/BRIEF.md
# DMA Descriptor Address Generator and Fetcher

This block locates and reads the per-channel control structures of a multi-channel DMA engine. Software writes a base pointer to the descriptor table. Software also keeps one select bit per channel that picks that channel's primary or alternate structure. The table has a primary area followed by an alternate area. Each channel owns a 16-byte slot in each area. Words inside a slot are at fixed offsets: the source end pointer at +0, the destination end pointer at +4 and the control word at +8. The word at +12 is never read.

When an arbiter grants a channel, the block samples that channel's select bit. It then issues three word reads in order on a request/acknowledge read port. Once the last word has been acknowledged, it presents the three captured words for one cycle, together with the channel number and the structure that was used. The distance between the primary and alternate areas, and the alignment forced onto the base pointer, both follow from the number of implemented channels. Decoding the control word and moving data are done by other blocks.

Top module: `dma_desc_fetch`

## Requirements
- R1: A base pointer write stores the written value with its low ALIGN bits forced to zero. ALIGN = ceil(log2(NUM_CH)) + 5, which is 8 for the default NUM_CH = 6. The stored value is the base of every later address.
- R2: The alternate area starts ALT_OFS bytes above the base. ALT_OFS = 16 × 2^ceil(log2(NUM_CH)), so it is 0x10, 0x20, 0x40, 0x80, 0x100 or 0x200 for 1, 2, 3–4, 5–8, 9–16 or 17–32 channels. The default NUM_CH = 6 gives 0x80.
- R3: alt_sel_o resets to all zeros. On a clock where alt_set_we_i is high, the bits set in alt_set_i become 1. On a clock where alt_clr_we_i is high, the bits set in alt_clr_i become 0. When both enables are high on the same bit, set wins. All other bits keep their value. A bit value of 1 selects the alternate structure.
- R4: A read address is base + (alternate ? ALT_OFS : 0) + 16 × channel + 4 × word. Word 0 is the source end pointer, word 1 is the destination end pointer and word 2 is the control word. Word 3 is never requested.
- R5: After a grant is accepted, exactly three reads are issued, in the order word 0, word 1, word 2. Each request stays high with a stable address until the clock on which mem_ack_i is high. grant_ready_o is low while reads are pending.
- R6: desc_valid_o is high for exactly one cycle, the cycle after the third acknowledge. In that cycle desc_src_o, desc_dst_o and desc_ctrl_o hold the data returned for words 0, 1 and 2, and desc_ch_o and desc_alt_o hold the granted channel and the structure used.
- R7: The select bit is sampled on the clock that accepts the grant. Changing it during the fetch does not change the addresses of that fetch.
- R8: A grant whose channel is NUM_CH or higher is ignored: no read is issued, no descriptor is produced, and grant_ready_o stays high.
- R9: After reset, mem_req_o and desc_valid_o are low, grant_ready_o is high and the stored base is zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Base pointer write strobe |
| base_wdata_i | input | AW | Base pointer write value |
| alt_set_we_i | input | 1 | Select-bit set strobe |
| alt_set_i | input | NUM_CH | Bits to set |
| alt_clr_we_i | input | 1 | Select-bit clear strobe |
| alt_clr_i | input | NUM_CH | Bits to clear |
| alt_sel_o | output | NUM_CH | Per-channel select (1 = alternate) |
| grant_valid_i | input | 1 | Channel grant |
| grant_ch_i | input | CHW | Granted channel number |
| grant_ready_o | output | 1 | Idle, grant is accepted |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read byte address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | DW | Read data |
| desc_valid_o | output | 1 | Descriptor ready, one-cycle pulse |
| desc_ch_o | output | CHW | Channel of the descriptor |
| desc_alt_o | output | 1 | Alternate structure used |
| desc_src_o | output | DW | Source end pointer |
| desc_dst_o | output | DW | Destination end pointer |
| desc_ctrl_o | output | DW | Control word |

## Verification
A wrong base mask, alternate offset or channel stride shows up on mem_addr_o at the first request after the grant, which is one cycle after acceptance. A stuck or skipped word index changes the address of the second or third read, or the number of reads. It also moves the desc_valid_o pulse, which is normally due one cycle after the third acknowledge. A select register that fails to take a set or clear sends the next fetch of that channel to the wrong area. A select bit sampled late lets a write made during the fetch leak into its addresses.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  localparam int unsigned DESC_WORDS = 3;
  localparam int unsigned SLOT_BYTES = 16;

  typedef enum logic {
    ST_IDLE,
    ST_READ
  } seq_state_e;

  function automatic int unsigned ch_bits_f(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // distance from primary to alternate area
  function automatic int unsigned alt_ofs_f(input int unsigned n);
    return SLOT_BYTES << $clog2(n);
  endfunction

  // log2 of total table size
  function automatic int unsigned align_bits_f(input int unsigned n);
    return $clog2(n) + 5;
  endfunction
endpackage

// File: rtl/dma_desc_base_reg.sv
module dma_desc_base_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o
);
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << ALIGN) - AW'(1);

  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (we_i) base_q <= wdata_i & ~LOW_MASK;
  end

  assign base_o = base_q;
endmodule

// File: rtl/dma_alt_sel_reg.sv
module dma_alt_sel_reg #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] sel_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
    logic sel_q;
    logic do_set, do_clr;
    assign do_set = set_we_i & set_i[c];
    assign do_clr = clr_we_i & clr_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q <= 1'b0;
      else if (do_set) sel_q <= 1'b1;  // set dominates
      else if (do_clr) sel_q <= 1'b0;
    end

    assign sel_o[c] = sel_q;
  end
endmodule

// File: rtl/dma_desc_addr.sv
module dma_desc_addr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CHW    = 3
) (
  input  logic [AW-1:0]  base_i,
  input  logic [CHW-1:0] ch_i,
  input  logic           alt_i,
  input  logic [1:0]     word_i,
  output logic [AW-1:0]  addr_o
);
  import dma_desc_pkg::*;

  localparam logic [AW-1:0] ALT_OFS = AW'(alt_ofs_f(NUM_CH));

  logic [AW-1:0] area_ofs, slot_ofs, word_ofs;

  assign area_ofs = alt_i ? ALT_OFS : '0;
  assign slot_ofs = AW'(ch_i) << 4;
  assign word_ofs = AW'(word_i) << 2;
  assign addr_o   = base_i + area_ofs + slot_ofs + word_ofs;
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CHW    = 3,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] alt_sel_i,
  input  logic              grant_valid_i,
  input  logic [CHW-1:0]    grant_ch_i,
  output logic              grant_ready_o,
  output logic              rd_req_o,
  output logic [CHW-1:0]    rd_ch_o,
  output logic              rd_alt_o,
  output logic [1:0]        rd_word_o,
  input  logic              rd_ack_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              desc_valid_o,
  output logic [DW-1:0]     desc_src_o,
  output logic [DW-1:0]     desc_dst_o,
  output logic [DW-1:0]     desc_ctrl_o
);
  import dma_desc_pkg::*;

  localparam int unsigned CHP  = 1 << CHW;
  localparam logic [1:0]  LAST = 2'(DESC_WORDS - 1);

  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q;
  logic           alt_q;
  logic [1:0]     word_q;
  logic           valid_q;
  logic [CHP-1:0] sel_ext;
  logic           ch_ok, accept, beat, last_beat;
  logic [DW-1:0]  word_data_q [DESC_WORDS];

  assign sel_ext   = CHP'(alt_sel_i);
  assign ch_ok     = {1'b0, grant_ch_i} < (CHW+1)'(NUM_CH);
  assign accept    = (state_q == ST_IDLE) && grant_valid_i && ch_ok;
  assign beat      = (state_q == ST_READ) && rd_ack_i;
  assign last_beat = beat && (word_q == LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_READ;
      ST_READ: if (last_beat) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      alt_q   <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= last_beat;
      if (accept) begin
        ch_q   <= grant_ch_i;
        alt_q  <= sel_ext[grant_ch_i];  // select frozen at grant
        word_q <= '0;
      end else if (beat && !last_beat) begin
        word_q <= word_q + 2'd1;
      end
    end
  end

  for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         word_data_q[w] <= '0;
      else if (beat && word_q == 2'(w))    word_data_q[w] <= rd_data_i;
    end
  end

  assign grant_ready_o = (state_q == ST_IDLE);
  assign rd_req_o      = (state_q == ST_READ);
  assign rd_ch_o       = ch_q;
  assign rd_alt_o      = alt_q;
  assign rd_word_o     = word_q;
  assign desc_valid_o  = valid_q;
  assign desc_src_o    = word_data_q[0];
  assign desc_dst_o    = word_data_q[1];
  assign desc_ctrl_o   = word_data_q[2];
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned CHW    = dma_desc_pkg::ch_bits_f(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [AW-1:0]     base_wdata_i,
  input  logic              alt_set_we_i,
  input  logic [NUM_CH-1:0] alt_set_i,
  input  logic              alt_clr_we_i,
  input  logic [NUM_CH-1:0] alt_clr_i,
  output logic [NUM_CH-1:0] alt_sel_o,
  input  logic              grant_valid_i,
  input  logic [CHW-1:0]    grant_ch_i,
  output logic              grant_ready_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              desc_valid_o,
  output logic [CHW-1:0]    desc_ch_o,
  output logic              desc_alt_o,
  output logic [DW-1:0]     desc_src_o,
  output logic [DW-1:0]     desc_dst_o,
  output logic [DW-1:0]     desc_ctrl_o
);
  import dma_desc_pkg::*;

  localparam int unsigned ALIGN = align_bits_f(NUM_CH);

  logic [AW-1:0]  base;
  logic [CHW-1:0] rd_ch;
  logic           rd_alt;
  logic [1:0]     rd_word;

  dma_desc_base_reg #(.AW(AW), .ALIGN(ALIGN)) i_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (base_we_i),
    .wdata_i(base_wdata_i),
    .base_o (base)
  );

  dma_alt_sel_reg #(.NUM_CH(NUM_CH)) i_alt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(alt_set_we_i),
    .set_i   (alt_set_i),
    .clr_we_i(alt_clr_we_i),
    .clr_i   (alt_clr_i),
    .sel_o   (alt_sel_o)
  );

  dma_desc_seq #(.NUM_CH(NUM_CH), .CHW(CHW), .DW(DW)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alt_sel_i    (alt_sel_o),
    .grant_valid_i(grant_valid_i),
    .grant_ch_i   (grant_ch_i),
    .grant_ready_o(grant_ready_o),
    .rd_req_o     (mem_req_o),
    .rd_ch_o      (rd_ch),
    .rd_alt_o     (rd_alt),
    .rd_word_o    (rd_word),
    .rd_ack_i     (mem_ack_i),
    .rd_data_i    (mem_rdata_i),
    .desc_valid_o (desc_valid_o),
    .desc_src_o   (desc_src_o),
    .desc_dst_o   (desc_dst_o),
    .desc_ctrl_o  (desc_ctrl_o)
  );

  dma_desc_addr #(.AW(AW), .NUM_CH(NUM_CH), .CHW(CHW)) i_addr (
    .base_i(base),
    .ch_i  (rd_ch),
    .alt_i (rd_alt),
    .word_i(rd_word),
    .addr_o(mem_addr_o)
  );

  assign desc_ch_o  = rd_ch;
  assign desc_alt_o = rd_alt;
endmodule

// File: rtl/dma_desc_fetch_chk.sv
module dma_desc_fetch_chk #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned AW     = 32,
  parameter int unsigned CHW    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alt_set_we_i,
  input logic [NUM_CH-1:0] alt_set_i,
  input logic              alt_clr_we_i,
  input logic [NUM_CH-1:0] alt_clr_i,
  input logic [NUM_CH-1:0] alt_sel_o,
  input logic              grant_valid_i,
  input logic [CHW-1:0]    grant_ch_i,
  input logic              grant_ready_o,
  input logic              mem_req_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_ack_i,
  input logic              desc_valid_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R5

  AST_NO_REQ_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ready_o |-> !mem_req_o); // R5

  AST_WORD_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |=> !desc_valid_o); // R6

  AST_ALT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_set_we_i |=> ((alt_sel_o & $past(alt_set_i)) == $past(alt_set_i))); // R3

  AST_ALT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_clr_we_i && !alt_set_we_i) |=> ((alt_sel_o & $past(alt_clr_i)) == '0)); // R3

  AST_BAD_CH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_ready_o && grant_valid_i && ({1'b0, grant_ch_i} >= (CHW+1)'(NUM_CH)))
      |=> (grant_ready_o && !mem_req_o)); // R8
endmodule

bind dma_desc_fetch dma_desc_fetch_chk #(.NUM_CH(NUM_CH), .AW(AW), .CHW(CHW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alt_set_we_i (alt_set_we_i),
  .alt_set_i    (alt_set_i),
  .alt_clr_we_i (alt_clr_we_i),
  .alt_clr_i    (alt_clr_i),
  .alt_sel_o    (alt_sel_o),
  .grant_valid_i(grant_valid_i),
  .grant_ch_i   (grant_ch_i),
  .grant_ready_o(grant_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .desc_valid_o (desc_valid_o)
);

// File: tb/test_dma_desc_fetch.sv
`timescale 1ns/1ps
module test_dma_desc_fetch;
  localparam int N   = 6;
  localparam int CHW = 3;
  localparam logic [31:0] ALT_OFS  = 32'h80;   // R2: 5..8 channels
  localparam logic [31:0] LOW_MASK = 32'hFF;   // R1: ALIGN = 8

  logic clk = 0, rst_n = 0;
  logic base_we = 0; logic [31:0] base_wdata = '0;
  logic set_we = 0, clr_we = 0; logic [N-1:0] set_v = '0, clr_v = '0;
  logic [N-1:0] alt_sel;
  logic grant_valid = 0; logic [CHW-1:0] grant_ch = '0; logic grant_ready;
  logic mem_req, mem_ack = 0; logic [31:0] mem_addr, mem_rdata = '0;
  logic desc_valid, desc_alt; logic [CHW-1:0] desc_ch;
  logic [31:0] desc_src, desc_dst, desc_ctrl;

  int total = 0, bad = 0, cycles = 0;
  int ack_lat = 0, wcnt = 0, log_n = 0, req_cycles = 0, v_n = 0;
  logic [31:0] log_addr [0:255];
  logic [31:0] cap_src, cap_dst, cap_ctrl; logic [CHW-1:0] cap_ch; logic cap_alt;
  logic [31:0] base_exp = '0;

  always #2.5 clk = ~clk;

  dma_desc_fetch i_dma_desc_fetch (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .alt_set_we_i(set_we), .alt_set_i(set_v),
    .alt_clr_we_i(clr_we), .alt_clr_i(clr_v), .alt_sel_o(alt_sel),
    .grant_valid_i(grant_valid), .grant_ch_i(grant_ch), .grant_ready_o(grant_ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .desc_valid_o(desc_valid), .desc_ch_o(desc_ch), .desc_alt_o(desc_alt),
    .desc_src_o(desc_src), .desc_dst_o(desc_dst), .desc_ctrl_o(desc_ctrl)
  );

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  // memory responder and descriptor monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; wcnt = 0;
    end else begin
      if (desc_valid) begin
        v_n++; cap_src = desc_src; cap_dst = desc_dst; cap_ctrl = desc_ctrl;
        cap_ch = desc_ch; cap_alt = desc_alt;
      end
      if (mem_req) req_cycles++;
      if (mem_ack) begin
        mem_ack = 0; wcnt = 0;
      end else if (mem_req) begin
        if (wcnt >= ack_lat) begin
          mem_ack = 1; mem_rdata = mem_f(mem_addr);
          if (log_n < 256) log_addr[log_n] = mem_addr;
          log_n++;
        end else wcnt++;
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=20000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic write_base(input logic [31:0] v);
    tick(); base_we = 1; base_wdata = v;
    tick(); base_we = 0;
    base_exp = v & ~LOW_MASK;
  endtask

  task automatic write_alt(input bit s, input logic [N-1:0] sv, input bit c, input logic [N-1:0] cv);
    tick(); set_we = s; set_v = sv; clr_we = c; clr_v = cv;
    tick(); set_we = 0; clr_we = 0;
  endtask

  task automatic t_reset();
    tick();
    check(grant_ready == 1, "R9 ready", 32'(grant_ready), 1);
    check(mem_req == 0, "R9 req", 32'(mem_req), 0);
    check(desc_valid == 0, "R9 valid", 32'(desc_valid), 0);
    check(alt_sel == '0, "R3 reset sel", 32'(alt_sel), 0);
  endtask

  task automatic t_alt_reg();
    write_alt(1, 6'b101101, 0, '0);
    check(alt_sel == 6'b101101, "R3 set", 32'(alt_sel), 32'h2d);
    write_alt(0, '0, 1, 6'b000101);
    check(alt_sel == 6'b101000, "R3 clear", 32'(alt_sel), 32'h28);
    write_alt(1, 6'b000011, 1, 6'b001001);
    check(alt_sel == 6'b100011, "R3 set wins", 32'(alt_sel), 32'h23);
  endtask

  // poke: write the opposite select for ch during the fetch (R7)
  task automatic run_fetch(input int ch, input bit alt, input int lat, input bit poke, input string tag);
    int v0, l0, r0;
    logic [31:0] a;
    v0 = v_n; l0 = log_n; r0 = req_cycles; ack_lat = lat;
    tick(); grant_valid = 1; grant_ch = CHW'(ch);
    tick(); grant_valid = 0;
    check(grant_ready == 0, {"R5 busy ", tag}, 32'(grant_ready), 0);
    if (poke) begin
      if (alt) write_alt(0, '0, 1, N'(1) << ch);
      else     write_alt(1, N'(1) << ch, 0, '0);
    end
    for (int i = 0; i < 100 && v_n == v0; i++) tick();
    repeat (3) tick();
    check(v_n == v0 + 1, {"R6 one pulse ", tag}, 32'(v_n - v0), 1);
    check(log_n == l0 + 3, {"R5 three reads ", tag}, 32'(log_n - l0), 3);
    for (int w = 0; w < 3; w++) begin
      a = base_exp + (alt ? ALT_OFS : 32'h0) + 32'(ch * 16) + 32'(w * 4);
      check(log_addr[l0 + w] == a, {"R4 addr ", tag}, log_addr[l0 + w], a);
    end
    a = base_exp + (alt ? ALT_OFS : 32'h0) + 32'(ch * 16);
    check(cap_src == mem_f(a), {"R6 src ", tag}, cap_src, mem_f(a));
    check(cap_dst == mem_f(a + 4), {"R6 dst ", tag}, cap_dst, mem_f(a + 4));
    check(cap_ctrl == mem_f(a + 8), {"R6 ctrl ", tag}, cap_ctrl, mem_f(a + 8));
    check(cap_ch == CHW'(ch) && cap_alt == alt, {"R6 ch/alt ", tag},
          {28'h0, cap_alt, cap_ch}, {28'h0, alt, 3'(ch)});
    if (lat > 0)
      check(req_cycles - r0 >= 3 * (lat + 1), {"R5 held until ack ", tag},
            32'(req_cycles - r0), 32'(3 * (lat + 1)));
  endtask

  task automatic t_fetch_base();
    write_base(32'h2000_01F3);  // R1: low 8 bits dropped
    run_fetch(2, 0, 0, 0, "R1 base ch2 primary");
    run_fetch(5, 1, 3, 0, "R2 ch5 alternate");
    run_fetch(0, 1, 1, 0, "R2 ch0 alternate");
    write_base(32'h1234_5678);
    run_fetch(4, 0, 2, 0, "R1 base2 ch4");
  endtask

  task automatic t_mid_change();
    run_fetch(3, 0, 4, 1, "R7 sel set mid-fetch");
    run_fetch(3, 1, 0, 0, "R7 new sel used");
    run_fetch(3, 1, 4, 1, "R7 sel clr mid-fetch");
  endtask

  task automatic t_bad_ch();
    int r0, v0;
    r0 = req_cycles; v0 = v_n;
    tick(); grant_valid = 1; grant_ch = 3'd7;
    tick(); grant_ch = 3'd6;
    tick(); grant_valid = 0;
    repeat (4) tick();
    check(req_cycles == r0, "R8 no read", 32'(req_cycles - r0), 0);
    check(v_n == v0, "R8 no descriptor", 32'(v_n - v0), 0);
    check(grant_ready == 1, "R8 ready kept", 32'(grant_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alt_reg();
    t_fetch_base();
    t_mid_change();
    t_bad_ch();
    summary();
  end
endmodule